// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block sits next to a 32-bit processor pipeline and handles the switch into and out of exception handlers. It recognises three request classes: a reset request, a general exception (any fault raised by the instruction in flight) and an external interrupt. On entry it saves the interrupted program counter and status word into shadow registers. It raises the privilege, register-bank and block control bits of the status word and latches the 12-bit event code into the event register that matches the class. It then issues a one-cycle fetch redirect to the handler vector.

A return strobe does the reverse. The saved program counter becomes the redirect target, and the saved status word is handed back to the pipeline for loading. A general exception aborts the instruction that raised it and is taken at once. An interrupt waits for the instruction-boundary strobe, and it is refused while the block bit of the current status word is set.

All state changes happen on a single clock edge. Every output is registered, so the pipeline sees the result one cycle after the request. Between pulses the redirect target and the status word hold their last values.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, every output register clears to zero: `redirect_vld`, `redirect_pc`, `sr_load`, `sr_new`, `spc`, `ssr`, `ev_exc`, `ev_int` and `ev_int2`.
- R2: A general exception is taken in any cycle that `gen_req` is high. An interrupt is taken only in a cycle where `insn_done` is also high; otherwise it has no effect.
- R3: On general-exception or interrupt entry, `spc` takes `cur_pc` and `ssr` takes `cur_sr` from the request cycle.
- R4: On any entry, `sr_new` equals `cur_sr` with bit 30 (privileged mode), bit 29 (register bank) and bit 28 (block) forced to 1 and all other bits copied. `sr_load` pulses for that one cycle.
- R5: An interrupt request is ignored while `cur_sr[28]` is 1, with no change to any output. A general exception is still taken in that state.
- R6: A general exception writes `gen_code` zero-extended into `ev_exc`. An interrupt writes `irq_code` zero-extended into both `ev_int` and `ev_int2`. No other event register changes.
- R7: `redirect_vld` is high for exactly one cycle, the cycle after an accepted request. `redirect_pc` is `vec_base + 0x100` for a general exception and `vec_base + 0x600` for an interrupt.
- R8: A reset request redirects to the fixed address `RESET_ADDR` (default 0xA000_0000) and sets the same three status bits. It writes `RESET_CODE` (default 0) into `ev_exc` and leaves `spc`, `ssr`, `ev_int` and `ev_int2` unchanged.
- R9: When requests coincide, reset wins over a general exception, which wins over an accepted interrupt, which wins over a return.
- R10: A return with nothing of higher priority pending redirects to `spc` and puts `ssr` on `sr_new` with a `sr_load` pulse. `spc`, `ssr` and the event registers stay unchanged.
- R11: In a cycle with no accepted request, `redirect_vld` and `sr_load` are low next cycle, and `redirect_pc` and `sr_new` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_req | input | 1 | Reset-class exception request |
| gen_req | input | 1 | General exception request, aborts current instruction |
| gen_code | input | 12 | Event code of the general exception |
| irq_req | input | 1 | Interrupt request |
| irq_code | input | 12 | Event code of the interrupt |
| insn_done | input | 1 | Current instruction completes this cycle |
| rte_req | input | 1 | Return-from-exception request |
| cur_pc | input | 32 | Program counter of the current instruction |
| cur_sr | input | 32 | Current status word |
| vec_base | input | 32 | Handler vector base address |
| redirect_vld | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc | output | 32 | Redirect target address |
| sr_load | output | 1 | One-cycle strobe to load `sr_new` into the status word |
| sr_new | output | 32 | Status word value to load |
| spc | output | 32 | Saved program counter |
| ssr | output | 32 | Saved status word |
| ev_exc | output | 32 | General-exception event register |
| ev_int | output | 32 | Primary interrupt event register |
| ev_int2 | output | 32 | Secondary interrupt event register |

## Verification
The bench covers several corner cases:
- an interrupt raised between instruction boundaries, which a wrong design would take early and so corrupt the saved PC;
- an interrupt raised with the block bit set, which a faulty mask would let through and so overwrite the shadow registers of a running handler;
- coincident requests in every ordering, where a priority slip would send fetch to the wrong vector or save context on a reset;
- a return issued right after an entry, which catches a design that restores stale or just-overwritten shadow values;
- the zero-extension of the event codes and the separate updates of the exception and interrupt event registers.

// File: rtl/exc_pkg.sv
// Shared types and status-word bit positions for the exception controller.
// Assumes a 32-bit status word with the three control bits at 30..28.
package exc_pkg;
    typedef enum logic [2:0] {
        EK_NONE  = 3'd0,
        EK_RESET = 3'd1,
        EK_GEN   = 3'd2,
        EK_IRQ   = 3'd3,
        EK_RTE   = 3'd4
    } exc_kind_e;

    localparam int SR_MODE_POS  = 30;
    localparam int SR_BANK_POS  = 29;
    localparam int SR_BLOCK_POS = 28;
endpackage

// File: rtl/exc_select.sv
// Picks the one event acted on this cycle from the raw requests.
// Assumes requests are single-cycle level inputs sampled at the clock edge.
module exc_select
    import exc_pkg::*;
(
    input  logic      rst_req,
    input  logic      gen_req,
    input  logic      irq_req,
    input  logic      insn_done,
    input  logic      rte_req,
    input  logic      block_bit,
    output exc_kind_e kind
);
    logic irq_ok;

    // Interrupt is eligible only at an instruction boundary and when unblocked.
    assign irq_ok = irq_req && insn_done && !block_bit;

    // Fixed priority: reset, general, interrupt, return.
    always_comb begin
        if (rst_req)      kind = EK_RESET;
        else if (gen_req) kind = EK_GEN;
        else if (irq_ok)  kind = EK_IRQ;
        else if (rte_req) kind = EK_RTE;
        else              kind = EK_NONE;
    end
endmodule

// File: rtl/exc_target.sv
// Computes the redirect address and the status word to load for an event.
// Assumes vector offsets fit in XLEN and that wrap-around of base+offset is acceptable.
module exc_target
    import exc_pkg::*;
#(
    parameter int               XLEN       = 32,
    parameter logic [XLEN-1:0]  RESET_ADDR = 32'hA000_0000,
    parameter logic [XLEN-1:0]  GEN_OFS    = 32'h0000_0100,
    parameter logic [XLEN-1:0]  IRQ_OFS    = 32'h0000_0600
) (
    input  exc_kind_e         kind,
    input  logic [XLEN-1:0]   vec_base,
    input  logic [XLEN-1:0]   cur_sr,
    input  logic [XLEN-1:0]   spc_q,
    input  logic [XLEN-1:0]   ssr_q,
    output logic [XLEN-1:0]   tgt_pc,
    output logic [XLEN-1:0]   tgt_sr
);
    localparam logic [XLEN-1:0] CTRL_MASK =
        (XLEN'(1) << SR_MODE_POS) | (XLEN'(1) << SR_BANK_POS) | (XLEN'(1) << SR_BLOCK_POS);

    logic [XLEN-1:0] entry_sr;

    // Entry status word: raise mode, bank and block, keep the rest.
    assign entry_sr = cur_sr | CTRL_MASK;

    // Select target address and status word by event kind.
    always_comb begin
        tgt_pc = '0;
        tgt_sr = entry_sr;
        unique case (kind)
            EK_RESET: tgt_pc = RESET_ADDR;
            EK_GEN:   tgt_pc = vec_base + GEN_OFS;
            EK_IRQ:   tgt_pc = vec_base + IRQ_OFS;
            EK_RTE: begin
                tgt_pc = spc_q;
                tgt_sr = ssr_q;
            end
            default:  tgt_pc = '0;
        endcase
    end
endmodule

// File: rtl/exc_state_regs.sv
// Holds the shadow, event and output registers; all update on one edge.
// Assumes a synchronous active-low reset and that kind is already prioritised.
module exc_state_regs
    import exc_pkg::*;
#(
    parameter int               XLEN       = 32,
    parameter int               CODE_W     = 12,
    parameter int               INT_EV_N   = 2,
    parameter logic [CODE_W-1:0] RESET_CODE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  exc_kind_e         kind,
    input  logic [XLEN-1:0]   tgt_pc,
    input  logic [XLEN-1:0]   tgt_sr,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   cur_sr,
    input  logic [CODE_W-1:0] gen_code,
    input  logic [CODE_W-1:0] irq_code,
    output logic              redirect_vld,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              sr_load,
    output logic [XLEN-1:0]   sr_new,
    output logic [XLEN-1:0]   spc,
    output logic [XLEN-1:0]   ssr,
    output logic [XLEN-1:0]   ev_exc,
    output logic [XLEN-1:0]   int_ev [INT_EV_N]
);
    localparam int PAD_W = XLEN - CODE_W;

    logic act;
    logic save_ctx;

    assign act      = (kind != EK_NONE);
    assign save_ctx = (kind == EK_GEN) || (kind == EK_IRQ);

    // Redirect strobe and target, status-word load strobe and value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_vld <= 1'b0;
            redirect_pc  <= '0;
            sr_load      <= 1'b0;
            sr_new       <= '0;
        end else begin
            redirect_vld <= act;
            sr_load      <= act;
            if (act) begin
                redirect_pc <= tgt_pc;
                sr_new      <= tgt_sr;
            end
        end
    end

    // Shadow copies of PC and SR for general exceptions and interrupts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spc <= '0;
            ssr <= '0;
        end else if (save_ctx) begin
            spc <= cur_pc;
            ssr <= cur_sr;
        end
    end

    // Exception event register: general code or the fixed reset code.
    always_ff @(posedge clk) begin
        if (!rst_n)                ev_exc <= '0;
        else if (kind == EK_GEN)   ev_exc <= {{PAD_W{1'b0}}, gen_code};
        else if (kind == EK_RESET) ev_exc <= {{PAD_W{1'b0}}, RESET_CODE};
    end

    // Interrupt event registers, one per copy, all loaded with the same code.
    for (genvar g = 0; g < INT_EV_N; g++) begin : g_int_ev
        always_ff @(posedge clk) begin
            if (!rst_n)              int_ev[g] <= '0;
            else if (kind == EK_IRQ) int_ev[g] <= {{PAD_W{1'b0}}, irq_code};
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
// Top of the exception entry and return controller.
// Assumes the pipeline loads sr_new when sr_load pulses and refetches on redirect_vld.
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int                XLEN       = 32,
    parameter int                CODE_W     = 12,
    parameter logic [XLEN-1:0]   RESET_ADDR = 32'hA000_0000,
    parameter logic [XLEN-1:0]   GEN_OFS    = 32'h0000_0100,
    parameter logic [XLEN-1:0]   IRQ_OFS    = 32'h0000_0600,
    parameter logic [CODE_W-1:0] RESET_CODE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_req,
    input  logic              gen_req,
    input  logic [CODE_W-1:0] gen_code,
    input  logic              irq_req,
    input  logic [CODE_W-1:0] irq_code,
    input  logic              insn_done,
    input  logic              rte_req,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   cur_sr,
    input  logic [XLEN-1:0]   vec_base,
    output logic              redirect_vld,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              sr_load,
    output logic [XLEN-1:0]   sr_new,
    output logic [XLEN-1:0]   spc,
    output logic [XLEN-1:0]   ssr,
    output logic [XLEN-1:0]   ev_exc,
    output logic [XLEN-1:0]   ev_int,
    output logic [XLEN-1:0]   ev_int2
);
    localparam int INT_EV_N = 2;

    exc_kind_e       kind;
    logic [XLEN-1:0] tgt_pc;
    logic [XLEN-1:0] tgt_sr;
    logic [XLEN-1:0] int_ev [INT_EV_N];

    exc_select u_select (
        .rst_req   (rst_req),
        .gen_req   (gen_req),
        .irq_req   (irq_req),
        .insn_done (insn_done),
        .rte_req   (rte_req),
        .block_bit (cur_sr[SR_BLOCK_POS]),
        .kind      (kind)
    );

    exc_target #(
        .XLEN       (XLEN),
        .RESET_ADDR (RESET_ADDR),
        .GEN_OFS    (GEN_OFS),
        .IRQ_OFS    (IRQ_OFS)
    ) u_target (
        .kind     (kind),
        .vec_base (vec_base),
        .cur_sr   (cur_sr),
        .spc_q    (spc),
        .ssr_q    (ssr),
        .tgt_pc   (tgt_pc),
        .tgt_sr   (tgt_sr)
    );

    exc_state_regs #(
        .XLEN       (XLEN),
        .CODE_W     (CODE_W),
        .INT_EV_N   (INT_EV_N),
        .RESET_CODE (RESET_CODE)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .kind         (kind),
        .tgt_pc       (tgt_pc),
        .tgt_sr       (tgt_sr),
        .cur_pc       (cur_pc),
        .cur_sr       (cur_sr),
        .gen_code     (gen_code),
        .irq_code     (irq_code),
        .redirect_vld (redirect_vld),
        .redirect_pc  (redirect_pc),
        .sr_load      (sr_load),
        .sr_new       (sr_new),
        .spc          (spc),
        .ssr          (ssr),
        .ev_exc       (ev_exc),
        .int_ev       (int_ev)
    );

    assign ev_int  = int_ev[0];
    assign ev_int2 = int_ev[1];
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
// Property checker for exc_entry_ctrl, attached by bind below.
// Assumes the reset polarity and bit positions of the top module.
module exc_entry_ctrl_chk #(
    parameter int                XLEN       = 32,
    parameter int                CODE_W     = 12,
    parameter logic [XLEN-1:0]   RESET_ADDR = 32'hA000_0000,
    parameter logic [XLEN-1:0]   GEN_OFS    = 32'h0000_0100,
    parameter logic [XLEN-1:0]   IRQ_OFS    = 32'h0000_0600
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rst_req,
    input logic              gen_req,
    input logic [CODE_W-1:0] gen_code,
    input logic              irq_req,
    input logic              insn_done,
    input logic              rte_req,
    input logic [XLEN-1:0]   cur_pc,
    input logic [XLEN-1:0]   cur_sr,
    input logic [XLEN-1:0]   vec_base,
    input logic              redirect_vld,
    input logic [XLEN-1:0]   redirect_pc,
    input logic              sr_load,
    input logic [XLEN-1:0]   sr_new,
    input logic [XLEN-1:0]   spc,
    input logic [XLEN-1:0]   ssr,
    input logic [XLEN-1:0]   ev_exc
);
    logic irq_take;
    assign irq_take = irq_req && insn_done && !cur_sr[28];

    assert_irq_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !insn_done && !rst_req && !gen_req && !rte_req) |=> !redirect_vld);

    assert_save_ctx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_req && !rst_req) |=> (spc == $past(cur_pc) && ssr == $past(cur_sr)));

    assert_ctrl_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || gen_req || irq_take) |=> (sr_load && sr_new[30:28] == 3'b111));

    assert_irq_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && cur_sr[28] && !rst_req && !gen_req && !rte_req) |=> !redirect_vld);

    assert_gen_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_req && !rst_req) |=> (ev_exc[CODE_W-1:0] == $past(gen_code)));

    assert_gen_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_req && !rst_req) |=> (redirect_vld && redirect_pc == $past(vec_base) + GEN_OFS));

    assert_irq_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && !rst_req && !gen_req) |=> (redirect_vld && redirect_pc == $past(vec_base) + IRQ_OFS));

    assert_reset_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (redirect_pc == RESET_ADDR && $stable(spc) && $stable(ssr)));

    assert_rte_restore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rte_req && !rst_req && !gen_req && !irq_take) |=>
            (redirect_pc == $past(spc) && sr_new == $past(ssr) && $stable(spc)));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req && !gen_req && !irq_take && !rte_req) |=> (!redirect_vld && !sr_load));
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(
    .XLEN       (XLEN),
    .CODE_W     (CODE_W),
    .RESET_ADDR (RESET_ADDR),
    .GEN_OFS    (GEN_OFS),
    .IRQ_OFS    (IRQ_OFS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_req      (rst_req),
    .gen_req      (gen_req),
    .gen_code     (gen_code),
    .irq_req      (irq_req),
    .insn_done    (insn_done),
    .rte_req      (rte_req),
    .cur_pc       (cur_pc),
    .cur_sr       (cur_sr),
    .vec_base     (vec_base),
    .redirect_vld (redirect_vld),
    .redirect_pc  (redirect_pc),
    .sr_load      (sr_load),
    .sr_new       (sr_new),
    .spc          (spc),
    .ssr          (ssr),
    .ev_exc       (ev_exc)
);

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model updated on each rising edge,
// compared with every DUT output on each falling edge.
module exc_entry_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_req = 1'b0, gen_req = 1'b0, irq_req = 1'b0;
    logic        insn_done = 1'b0, rte_req = 1'b0;
    logic [11:0] gen_code = '0, irq_code = '0;
    logic [31:0] cur_pc = '0, cur_sr = '0, vec_base = '0;
    logic        redirect_vld, sr_load;
    logic [31:0] redirect_pc, sr_new, spc, ssr, ev_exc, ev_int, ev_int2;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference state
    bit          m_vld, m_load;
    logic [31:0] m_pc, m_sr, m_spc, m_ssr, m_exc, m_int, m_int2;

    always #2.5 clk = ~clk;

    exc_entry_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .gen_req(gen_req),
        .gen_code(gen_code), .irq_req(irq_req), .irq_code(irq_code),
        .insn_done(insn_done), .rte_req(rte_req), .cur_pc(cur_pc),
        .cur_sr(cur_sr), .vec_base(vec_base), .redirect_vld(redirect_vld),
        .redirect_pc(redirect_pc), .sr_load(sr_load), .sr_new(sr_new),
        .spc(spc), .ssr(ssr), .ev_exc(ev_exc), .ev_int(ev_int), .ev_int2(ev_int2)
    );

    // Reference model: next state from the requirement text.
    always @(posedge clk) begin
        logic [31:0] raised;
        logic [31:0] old_spc, old_ssr;
        raised  = cur_sr | 32'h7000_0000;
        old_spc = m_spc;
        old_ssr = m_ssr;
        if (!rst_n) begin
            m_vld = 0; m_load = 0; m_pc = 0; m_sr = 0;
            m_spc = 0; m_ssr = 0; m_exc = 0; m_int = 0; m_int2 = 0;
        end else if (rst_req) begin
            m_vld = 1; m_load = 1; m_pc = 32'hA000_0000; m_sr = raised; m_exc = 0;
        end else if (gen_req) begin
            m_vld = 1; m_load = 1; m_pc = vec_base + 32'h100; m_sr = raised;
            m_spc = cur_pc; m_ssr = cur_sr; m_exc = {20'd0, gen_code};
        end else if (irq_req && insn_done && !cur_sr[28]) begin
            m_vld = 1; m_load = 1; m_pc = vec_base + 32'h600; m_sr = raised;
            m_spc = cur_pc; m_ssr = cur_sr;
            m_int = {20'd0, irq_code}; m_int2 = {20'd0, irq_code};
        end else if (rte_req) begin
            m_vld = 1; m_load = 1; m_pc = old_spc; m_sr = old_ssr;
        end else begin
            m_vld = 0; m_load = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model.
    task automatic compare_all();
        chk("R7/R11 redirect_vld", {31'd0, redirect_vld}, {31'd0, m_vld});
        chk("R7/R8/R10 redirect_pc", redirect_pc, m_pc);
        chk("R4/R11 sr_load", {31'd0, sr_load}, {31'd0, m_load});
        chk("R4/R10 sr_new", sr_new, m_sr);
        chk("R3/R8 spc", spc, m_spc);
        chk("R3/R8 ssr", ssr, m_ssr);
        chk("R6/R8 ev_exc", ev_exc, m_exc);
        chk("R6 ev_int", ev_int, m_int);
        chk("R6 ev_int2", ev_int2, m_int2);
    endtask

    // Drive one cycle of stimulus at the falling edge after comparing.
    task automatic step(input bit r, input bit g, input bit i, input bit d, input bit t,
                        input logic [31:0] pc, input logic [31:0] sr);
        @(negedge clk);
        compare_all();
        rst_req = r; gen_req = g; irq_req = i; insn_done = d; rte_req = t;
        cur_pc = pc; cur_sr = sr;
        gen_code = gen_code + 12'h0A3;
        irq_code = irq_code + 12'h151;
    endtask

    initial begin
        vec_base = 32'h8C00_0000;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 redirect_vld", {31'd0, redirect_vld}, 32'd0);
        chk("R1 sr_new", sr_new, 32'd0);
        chk("R1 spc", spc, 32'd0);
        chk("R1 ev_int2", ev_int2, 32'd0);
        rst_n = 1'b1;
        step(0,0,0,0,0, 32'h0, 32'h0);
        step(0,0,0,0,0, 32'h0, 32'h0);
        // R2/R3/R6/R7: general exception
        step(0,1,0,0,0, 32'h1000_0040, 32'h0000_00F0);
        step(0,0,0,0,0, 32'h0, 32'h0);
        // R10: return restores
        step(0,0,0,0,1, 32'h2222_0000, 32'h7000_0000);
        step(0,0,0,0,0, 32'h0, 32'h0);
        // R2: interrupt off boundary ignored, then taken at boundary
        step(0,0,1,0,0, 32'h1000_0080, 32'h0000_0003);
        step(0,0,1,1,0, 32'h1000_0084, 32'h0000_0003);
        step(0,0,0,0,0, 32'h0, 32'h0);
        // R5: blocked interrupt ignored, general still taken
        step(0,0,1,1,0, 32'h1000_0100, 32'h1000_0000);
        step(0,1,0,0,0, 32'h1000_0104, 32'h1000_0005);
        step(0,0,0,0,0, 32'h0, 32'h0);
        // R8/R9: reset wins over all
        step(1,1,1,1,1, 32'h3333_0000, 32'h0000_0011);
        // R9: general over interrupt, interrupt over return
        step(0,1,1,1,0, 32'h4444_0000, 32'h0000_0022);
        step(0,0,1,1,1, 32'h5555_0000, 32'h0000_0033);
        // R10: return right after entry sees the new shadow values
        step(0,0,0,0,1, 32'h0, 32'h0);
        step(0,0,0,0,0, 32'h0, 32'h0);
        // mixed traffic
        for (int k = 0; k < 400; k++) begin
            logic [3:0] rb;
            rb = 4'($urandom);
            step(($urandom % 23) == 0, ($urandom % 7) == 0, rb[0], rb[1],
                 ($urandom % 5) == 0, $urandom, $urandom);
        end
        step(0,0,0,0,0, 32'h0, 32'h0);
        @(negedge clk);
        compare_all();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule